// File: doc/BRIEF.md
# Multi-channel serial status and interrupt aggregator

This block gathers the status of a bank of serial channels and turns it into one level-sensitive interrupt line. Each channel presents a 32-bit status word. The word mixes live inputs with sticky event flags. The live inputs are the four synchronized modem lines, receive-data-available and transmit-empty. The sticky flags are an overrun flag and one change flag per modem line.

Software clears a sticky flag by writing a one to its bit position. It can write back a status word it has just read without disturbing anything else. Each channel also has a small control word with three interrupt enables. The enables decide which conditions raise that channel's request.

The requests form a vector with one bit per channel. A channel mask removes channels from the vector, where a 1 blocks the channel, and every channel starts out blocked. A global enable then gates the combined line. The read side is a channel selector with combinational status and control read-back. The write side is four strobes that share one channel index and one data word.

Top module: `multi_irq_agg`

## Requirements
- R1: After reset, every sticky flag and every control word is zero. The channel mask is all ones, so every channel is blocked. The global enable is zero and `irq_o` is low.
- R2: Status bit 0 shows the channel's receive-data-available input with no delay. Bits 3, 4, 5 and 6 show DCD, DSR, CTS and RI after the synchronizer. With two stages, a level applied before edge k first reads back after edge k+1.
- R3: Any rising or falling edge on a synchronized modem line sets that line's sticky change flag one clock after the live bit changes. The DSR flag is bit 16, CTS is bit 17, DCD is bit 18 and RI is bit 22.
- R4: A one-cycle pulse on a channel's overrun input sets sticky status bit 13. The bit stays set after the pulse ends.
- R5: A status write clears only the sticky bits (13, 16, 17, 18, 22) that are one in the data word. Zeros in the data word and ones aimed at live bits change nothing. When a flag is set and cleared in the same cycle, it stays set.
- R6: Status bit 25 shows the transmit-empty input only while the channel's TX interrupt enable is set. Otherwise it reads 0.
- R7: The control word keeps only three bits: the modem-status enable at bit 0, the RX enable at bit 2 and the TX enable at bit 19. All other bits read back as 0.
- R8: A channel request is raised when any of these holds:
  - the modem-status enable is set and any change flag is set;
  - the RX enable is set and either receive-data-available or the overrun flag is set;
  - the TX enable is set and transmit-empty is high.
- R9: `pend_o` equals the request vector ANDed with the inverted channel mask. A mask write takes bits NUM_CH-1:0 of the data word.
- R10: `irq_o` is high exactly while the global enable is set and `pend_o` is nonzero. The global enable is written from bit 20 of the data word.
- R11: Status and control writes change only the channel named by `wr_ch_i`. `rd_ch_i` selects the channel whose words are read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcd_i | input | NUM_CH | Asynchronous DCD level, one bit per channel |
| dsr_i | input | NUM_CH | Asynchronous DSR level, one bit per channel |
| cts_i | input | NUM_CH | Asynchronous CTS level, one bit per channel |
| ri_i | input | NUM_CH | Asynchronous RI level, one bit per channel |
| rx_avail_i | input | NUM_CH | Receive data available, one bit per channel |
| tx_empty_i | input | NUM_CH | Transmit side empty, one bit per channel |
| ovr_evt_i | input | NUM_CH | Overrun event pulse, one bit per channel |
| stat_wr_i | input | 1 | Write-one-to-clear strobe for the status word of `wr_ch_i` |
| ctl_wr_i | input | 1 | Write strobe for the control word of `wr_ch_i` |
| mask_wr_i | input | 1 | Write strobe for the channel mask |
| gctl_wr_i | input | 1 | Write strobe for the global enable (data bit 20) |
| wr_ch_i | input | CH_W | Channel index for status and control writes |
| wr_data_i | input | 32 | Write data shared by all four strobes |
| rd_ch_i | input | CH_W | Channel index for read-back |
| stat_rdata_o | output | 32 | Status word of channel `rd_ch_i` |
| ctl_rdata_o | output | 32 | Control word of channel `rd_ch_i` |
| pend_o | output | NUM_CH | Request vector after the mask |
| irq_o | output | 1 | Level-sensitive combined interrupt |

## Verification
The bench builds the block with its defaults: sixteen channels and a two-stage synchronizer. At sixteen channels the mask is a full 16-bit field, and the highest channel index 15 can be decoded and masked. With two stages, the bench can show the exact cycle in which a live modem bit appears and the following cycle in which its change flag sets.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int WORD_W       = 32;

    // status word bit positions
    localparam int STAT_RX      = 0;
    localparam int STAT_DCD     = 3;
    localparam int STAT_DSR     = 4;
    localparam int STAT_CTS     = 5;
    localparam int STAT_RI      = 6;
    localparam int STAT_OVR     = 13;
    localparam int STAT_DSR_CHG = 16;
    localparam int STAT_CTS_CHG = 17;
    localparam int STAT_DCD_CHG = 18;
    localparam int STAT_RI_CHG  = 22;
    localparam int STAT_TXE     = 25;

    // control word bit positions
    localparam int CTL_MSR_IE   = 0;
    localparam int CTL_RX_IE    = 2;
    localparam int CTL_TX_IE    = 19;

    // global control bit
    localparam int GCTL_EN      = 20;

    typedef struct packed {
        logic ri;
        logic cts;
        logic dsr;
        logic dcd;
    } modem_t;

    localparam int MODEM_W = $bits(modem_t);

    typedef struct packed {
        logic msr_ie;
        logic rx_ie;
        logic tx_ie;
    } chan_ctl_t;

    typedef struct packed {
        modem_t    prev;
        modem_t    chg;
        logic      ovr;
        chan_ctl_t ctl;
    } chan_state_t;

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/chan_status.sv
module chan_status
    import irqagg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  modem_t            line_i,
    input  logic              rx_avail_i,
    input  logic              tx_empty_i,
    input  logic              ovr_evt_i,
    input  logic              clr_wr_i,
    input  modem_t            clr_flags_i,
    input  logic              clr_ovr_i,
    input  logic              ctl_wr_i,
    input  chan_ctl_t         ctl_new_i,
    output logic [WORD_W-1:0] stat_o,
    output logic [WORD_W-1:0] ctl_o,
    output logic              req_o
);

    modem_t      live;
    modem_t      edges;
    modem_t      clr_mask;
    chan_state_t st_d, st_q;

    modem_sync #(
        .WIDTH  (MODEM_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (live)
    );

    always_comb begin
        st_d     = st_q;
        edges    = live ^ st_q.prev;
        clr_mask = clr_wr_i ? clr_flags_i : '0;

        st_d.prev = live;
        // a new event outranks a same-cycle clear
        st_d.chg  = (st_q.chg & ~clr_mask) | edges;
        st_d.ovr  = (st_q.ovr & ~(clr_wr_i & clr_ovr_i)) | ovr_evt_i;
        if (ctl_wr_i) begin
            st_d.ctl = ctl_new_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_o               = '0;
        stat_o[STAT_RX]      = rx_avail_i;
        stat_o[STAT_DCD]     = live.dcd;
        stat_o[STAT_DSR]     = live.dsr;
        stat_o[STAT_CTS]     = live.cts;
        stat_o[STAT_RI]      = live.ri;
        stat_o[STAT_OVR]     = st_q.ovr;
        stat_o[STAT_DSR_CHG] = st_q.chg.dsr;
        stat_o[STAT_CTS_CHG] = st_q.chg.cts;
        stat_o[STAT_DCD_CHG] = st_q.chg.dcd;
        stat_o[STAT_RI_CHG]  = st_q.chg.ri;
        stat_o[STAT_TXE]     = tx_empty_i & st_q.ctl.tx_ie;

        ctl_o                = '0;
        ctl_o[CTL_MSR_IE]    = st_q.ctl.msr_ie;
        ctl_o[CTL_RX_IE]     = st_q.ctl.rx_ie;
        ctl_o[CTL_TX_IE]     = st_q.ctl.tx_ie;
    end

    assign req_o = (st_q.ctl.msr_ie & (|st_q.chg))
                 | (st_q.ctl.rx_ie  & (rx_avail_i | st_q.ovr))
                 | (st_q.ctl.tx_ie  & tx_empty_i);

endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr_i,
    input  logic [NUM_CH-1:0] mask_data_i,
    input  logic              gctl_wr_i,
    input  logic              gen_data_i,
    input  logic [NUM_CH-1:0] req_i,
    output logic [NUM_CH-1:0] pend_o,
    output logic              irq_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic              gen_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic              gen;
    } comb_state_t;

    comb_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (mask_wr_i) begin
            cs_d.mask = mask_data_i;
        end
        if (gctl_wr_i) begin
            cs_d.gen = gen_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q.mask <= '1;
            cs_q.gen  <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign pend_o = req_i & ~cs_q.mask;
    assign irq_o  = cs_q.gen & (|pend_o);
    assign mask_o = cs_q.mask;
    assign gen_o  = cs_q.gen;

endmodule

// File: rtl/multi_irq_agg.sv
module multi_irq_agg
    import irqagg_pkg::*;
#(
    parameter  int NUM_CH      = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dcd_i,
    input  logic [NUM_CH-1:0] dsr_i,
    input  logic [NUM_CH-1:0] cts_i,
    input  logic [NUM_CH-1:0] ri_i,
    input  logic [NUM_CH-1:0] rx_avail_i,
    input  logic [NUM_CH-1:0] tx_empty_i,
    input  logic [NUM_CH-1:0] ovr_evt_i,
    input  logic              stat_wr_i,
    input  logic              ctl_wr_i,
    input  logic              mask_wr_i,
    input  logic              gctl_wr_i,
    input  logic [CH_W-1:0]   wr_ch_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [CH_W-1:0]   rd_ch_i,
    output logic [WORD_W-1:0] stat_rdata_o,
    output logic [WORD_W-1:0] ctl_rdata_o,
    output logic [NUM_CH-1:0] pend_o,
    output logic              irq_o
);

    modem_t            clr_flags;
    chan_ctl_t         ctl_new;
    logic [NUM_CH-1:0] chan_req;
    logic [NUM_CH-1:0] chan_mask;
    logic              glb_en;
    logic [WORD_W-1:0] stat_all [NUM_CH];
    logic [WORD_W-1:0] ctl_all  [NUM_CH];
    logic              wdata_unused;

    assign clr_flags    = {wr_data_i[STAT_RI_CHG], wr_data_i[STAT_CTS_CHG],
                           wr_data_i[STAT_DSR_CHG], wr_data_i[STAT_DCD_CHG]};
    assign ctl_new      = {wr_data_i[CTL_MSR_IE], wr_data_i[CTL_RX_IE],
                           wr_data_i[CTL_TX_IE]};
    assign wdata_unused = ^wr_data_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        modem_t lines;
        logic   sel;

        assign lines = {ri_i[c], cts_i[c], dsr_i[c], dcd_i[c]};
        assign sel   = (wr_ch_i == CH_W'(c));

        chan_status #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_i      (lines),
            .rx_avail_i  (rx_avail_i[c]),
            .tx_empty_i  (tx_empty_i[c]),
            .ovr_evt_i   (ovr_evt_i[c]),
            .clr_wr_i    (stat_wr_i && sel),
            .clr_flags_i (clr_flags),
            .clr_ovr_i   (wr_data_i[STAT_OVR]),
            .ctl_wr_i    (ctl_wr_i && sel),
            .ctl_new_i   (ctl_new),
            .stat_o      (stat_all[c]),
            .ctl_o       (ctl_all[c]),
            .req_o       (chan_req[c])
        );
    end

    irq_combine #(
        .NUM_CH (NUM_CH)
    ) u_comb (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr_i   (mask_wr_i),
        .mask_data_i (wr_data_i[NUM_CH-1:0]),
        .gctl_wr_i   (gctl_wr_i),
        .gen_data_i  (wr_data_i[GCTL_EN]),
        .req_i       (chan_req),
        .pend_o      (pend_o),
        .irq_o       (irq_o),
        .mask_o      (chan_mask),
        .gen_o       (glb_en)
    );

    assign stat_rdata_o = stat_all[rd_ch_i];
    assign ctl_rdata_o  = ctl_all[rd_ch_i];

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_mask,
    input logic              glb_en,
    input logic [NUM_CH-1:0] chan_req,
    input logic [NUM_CH-1:0] pend_o,
    input logic              irq_o,
    input logic              mask_wr_i,
    input logic              gctl_wr_i
);

    // R1: the mask leaves reset blocking every channel
    a_r1_mask_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_mask == '1));

    // R1: the interrupt is low on leaving reset
    a_r1_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);

    // R9: a blocked channel never shows as pending
    a_r9_masked_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & chan_mask) == '0);

    // R9: a pending bit needs a raised request
    a_r9_pend_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~chan_req) == '0);

    // R9: the mask only moves on a mask write
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(chan_mask));

    // R10: the line needs the global enable and a pending channel
    a_r10_irq_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (glb_en && (pend_o != '0)));

    // R10: the line stays high while a source remains
    a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && (pend_o != '0)) |-> irq_o);

    // R10: the global enable only moves on its write strobe
    a_r10_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gctl_wr_i |=> $stable(glb_en));

endmodule

bind multi_irq_agg irqagg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_mask (chan_mask),
    .glb_en    (glb_en),
    .chan_req  (chan_req),
    .pend_o    (pend_o),
    .irq_o     (irq_o),
    .mask_wr_i (mask_wr_i),
    .gctl_wr_i (gctl_wr_i)
);

// File: tb/multi_irq_agg_bench.sv
`timescale 1ns/1ps
module multi_irq_agg_bench;

    localparam int N  = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dcd, dsr, cts, ri, rxa, txe, ovr;
    logic          stat_wr, ctl_wr, mask_wr, gctl_wr;
    logic [CW-1:0] wr_ch, rd_ch;
    logic [31:0]   wr_data;
    logic [31:0]   stat_rd, ctl_rd;
    logic [N-1:0]  pend;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    multi_irq_agg u_multi_irq_agg (
        .clk(clk), .rst_n(rst_n),
        .dcd_i(dcd), .dsr_i(dsr), .cts_i(cts), .ri_i(ri),
        .rx_avail_i(rxa), .tx_empty_i(txe), .ovr_evt_i(ovr),
        .stat_wr_i(stat_wr), .ctl_wr_i(ctl_wr), .mask_wr_i(mask_wr),
        .gctl_wr_i(gctl_wr), .wr_ch_i(wr_ch), .wr_data_i(wr_data),
        .rd_ch_i(rd_ch), .stat_rdata_o(stat_rd), .ctl_rdata_o(ctl_rd),
        .pend_o(pend), .irq_o(irq)
    );

    // ie = {msr_ie, rx_ie, tx_ie}
    typedef struct packed {
        logic [3:0]  ch;
        logic [2:0]  ie;
        logic        rx;
        logic        tx;
        logic [15:0] mask;
        logic        gen;
        logic        exp_pend;
        logic        exp_irq;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{4'd2,  3'b010, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0},
        '{4'd2,  3'b010, 1'b1, 1'b0, 16'hFFFB, 1'b1, 1'b1, 1'b1},
        '{4'd2,  3'b010, 1'b1, 1'b0, 16'hFFFB, 1'b0, 1'b1, 1'b0},
        '{4'd2,  3'b000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0},
        '{4'd7,  3'b001, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b1},
        '{4'd7,  3'b001, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0},
        '{4'd15, 3'b011, 1'b0, 1'b1, 16'h7FFF, 1'b1, 1'b1, 1'b1},
        '{4'd15, 3'b011, 1'b0, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0},
        '{4'd0,  3'b100, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0}
    };

    vec_t v;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_stat(input logic [CW-1:0] ch, input logic [31:0] d);
        @(negedge clk); stat_wr = 1'b1; wr_ch = ch; wr_data = d;
        @(negedge clk); stat_wr = 1'b0;
    endtask

    task automatic wr_ctl(input logic [CW-1:0] ch, input logic [31:0] d);
        @(negedge clk); ctl_wr = 1'b1; wr_ch = ch; wr_data = d;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_mask(input logic [15:0] m);
        @(negedge clk); mask_wr = 1'b1; wr_data = {16'h0, m};
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic wr_gen(input logic en);
        @(negedge clk); gctl_wr = 1'b1; wr_data = {11'h0, en, 20'h0};
        @(negedge clk); gctl_wr = 1'b0;
    endtask

    task automatic peek(input logic [CW-1:0] ch);
        rd_ch = ch;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        dcd = '0; dsr = '0; cts = '0; ri = '0; rxa = '0; txe = '0; ovr = '0;
        stat_wr = 0; ctl_wr = 0; mask_wr = 0; gctl_wr = 0;
        wr_ch = '0; rd_ch = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(4'd0);
        chk("R1 stat", stat_rd, 32'h0);
        chk("R1 ctl", ctl_rd, 32'h0);
        chk("R1 pend", {16'h0, pend}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        // R1 mask starts all ones: an enabled request stays blocked
        wr_ctl(4'd3, 32'h4);
        rxa[3] = 1'b1;
        wr_gen(1'b1);
        chk("R1 mask blocks", {16'h0, pend}, 32'h0);
        chk("R1 mask irq", {31'h0, irq}, 32'h0);
        rxa[3] = 1'b0;
        wr_ctl(4'd3, 32'h0);

        // table: R6, R8, R9, R10
        for (int k = 0; k < 9; k++) begin
            v = VEC[k];
            @(negedge clk);
            rxa = '0; txe = '0;
            rxa[v.ch] = v.rx;
            txe[v.ch] = v.tx;
            wr_ctl(v.ch, (32'(v.ie[2]) << 0) | (32'(v.ie[1]) << 2) | (32'(v.ie[0]) << 19));
            wr_mask(v.mask);
            wr_gen(v.gen);
            peek(v.ch);
            chk("R9 pend", {16'h0, pend}, {16'h0, 16'(v.exp_pend) << v.ch});
            chk("R10 irq", {31'h0, irq}, {31'h0, v.exp_irq});
            chk("R6 txe bit", {31'h0, stat_rd[25]}, {31'h0, v.tx & v.ie[0]});
            chk("R2 rx bit", {31'h0, stat_rd[0]}, {31'h0, v.rx});
        end
        @(negedge clk);
        rxa = '0; txe = '0;

        // R2/R3 rising edges on all four lines of channel 9
        @(negedge clk);
        dcd[9] = 1; dsr[9] = 1; cts[9] = 1; ri[9] = 1;
        rd_ch = 4'd9;
        @(negedge clk); #1;
        chk("R2 one stage", stat_rd, 32'h0);
        @(negedge clk); #1;
        chk("R2 live", stat_rd, 32'h0000_0078);
        @(negedge clk); #1;
        chk("R3 rise flags", stat_rd, 32'h0047_0078);

        // R5 write-one-clear
        wr_stat(4'd9, 32'h0000_0078);
        peek(4'd9);
        chk("R5 live untouched", stat_rd, 32'h0047_0078);
        wr_stat(4'd9, 32'h0001_0000);
        peek(4'd9);
        chk("R5 one flag", stat_rd, 32'h0046_0078);
        // R11 clear on another channel
        wr_stat(4'd6, 32'hFFFF_FFFF);
        peek(4'd9);
        chk("R11 other chan", stat_rd, 32'h0046_0078);

        // R8 modem-status request
        wr_ctl(4'd9, 32'h1);
        wr_mask(16'h0);
        wr_gen(1'b1);
        chk("R8 msr pend", {16'h0, pend}, 32'h0000_0200);
        chk("R10 msr irq", {31'h0, irq}, 32'h1);
        wr_stat(4'd9, 32'hFFFF_FFFF);
        peek(4'd9);
        chk("R5 clear all", stat_rd, 32'h0000_0078);
        chk("R8 drop", {16'h0, pend}, 32'h0);
        chk("R10 drop", {31'h0, irq}, 32'h0);

        // R3 falling edges
        @(negedge clk);
        dcd[9] = 0; dsr[9] = 0; cts[9] = 0; ri[9] = 0;
        repeat (3) @(negedge clk);
        peek(4'd9);
        chk("R3 fall flags", stat_rd, 32'h0047_0000);
        wr_stat(4'd9, 32'hFFFF_FFFF);

        // R4 overrun sticky
        @(negedge clk); ovr[6] = 1'b1;
        @(negedge clk); ovr[6] = 1'b0;
        peek(4'd6);
        chk("R4 overrun set", stat_rd, 32'h0000_2000);
        @(negedge clk); #1;
        chk("R4 overrun held", stat_rd, 32'h0000_2000);
        wr_ctl(4'd6, 32'h4);
        chk("R8 overrun req", {16'h0, pend}, 32'h0000_0040);
        // R5 set wins over clear
        @(negedge clk);
        stat_wr = 1'b1; wr_ch = 4'd6; wr_data = 32'h0000_2000; ovr[6] = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0; ovr[6] = 1'b0;
        peek(4'd6);
        chk("R5 set wins", stat_rd, 32'h0000_2000);
        wr_stat(4'd6, 32'h0000_2000);
        peek(4'd6);
        chk("R5 overrun clear", stat_rd, 32'h0);
        chk("R8 overrun gone", {16'h0, pend}, 32'h0);

        // R7 control keeps three bits, R11 neighbour untouched
        wr_ctl(4'd5, 32'hFFFF_FFFF);
        peek(4'd5);
        chk("R7 ctl bits", ctl_rd, 32'h0008_0005);
        peek(4'd4);
        chk("R11 ctl other", ctl_rd, 32'h0);
        txe[5] = 1'b1;
        peek(4'd5);
        chk("R6 txe shown", stat_rd, 32'h0200_0000);
        chk("R8 tx req", {16'h0, pend}, 32'h0000_0020);
        wr_gen(1'b0);
        chk("R10 gen off", {31'h0, irq}, 32'h0);
        chk("R10 pend kept", {16'h0, pend}, 32'h0000_0020);

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        peek(4'd5);
        chk("R1 ctl cleared", ctl_rd, 32'h0);
        chk("R1 txe hidden", stat_rd, 32'h0);
        chk("R1 pend cleared", {16'h0, pend}, 32'h0);
        chk("R1 irq cleared", {31'h0, irq}, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule